// File: doc/BRIEF.md
# Scrambled CRC Frame Encoder

This block turns a stream of 30-bit payload words into 120-bit transmit frames, each sent as four consecutive 30-bit words for a 30:1 serializer. A frame begins with a one-cycle start strobe that comes with its first word. A mode input chooses between two layouts. Data mode carries 96 payload bits and a 16-bit CRC. Calibration mode carries 112 payload bits and no CRC. Both layouts end with an 8-bit trailer supplied from outside.

Payload bits pass through a self-synchronizing scrambler with the polynomial x^58 + x^39 + 1, 30 bits per clock. In the same cycle the CRC is computed over the unscrambled payload. The CRC and trailer go out unscrambled and do not advance the scrambler. The scrambler history has no reset. It is held in three copies, and every copy reloads from a bitwise majority of all three, so a single upset is corrected on the next clock. Each output word is registered once.

Top module: `frame_encoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, out_word is all zeros and out_sof is low.
- R2: frame_start marks word 0 of a frame, and words 1 to 3 follow on the next three cycles. Each output word appears one cycle after its input word, and out_sof is high with word 0. A new frame_start may come only after all four words of the previous frame.
- R3: Bits 7:0 of output word 3 hold, unscrambled, the trailer value presented with input word 3. This holds in both modes. The trailer input is ignored on the other cycles.
- R4: Data mode. The payload is words 0 to 2 plus bits 29:24 of word 3 (96 bits). Output word 3 bits 23:8 hold a CRC-16 over the unscrambled payload: polynomial 0x8005, zero seed for each frame, no final inversion, bit 29 of word 0 first. The CRC MSB is at bit 23. Input bits 23:0 of word 3 are ignored.
- R5: Calibration mode. The payload is words 0 to 2 plus bits 29:8 of word 3 (112 bits), and all of it is scrambled. Input bits 7:0 of word 3 are ignored.
- R6: Each payload output bit equals the input bit XOR the payload output bits 39 and 58 positions earlier. Bits are taken bit 29 first, in word order, so descrambling the output recovers the payload.
- R7: Only payload bits advance the scrambler. CRC bits, trailer bits and idle cycles leave its history unchanged, so the relation in R6 holds across frame boundaries and gaps.
- R8: The mode is sampled with frame_start. Changes on cal_mode during words 1 to 3 have no effect on that frame.
- R9: Reset does not clear the scrambler history. It is held in three copies, each loaded from their bitwise majority, and the copies agree on every cycle after reset.
- R10: Outside a frame, out_word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | High with word 0 of a frame |
| cal_mode | input | 1 | 1 = calibration layout, 0 = data layout; sampled with frame_start |
| in_word | input | 30 | Payload word, bit 29 sent first |
| trailer | input | 8 | Trailer value, taken with word 3 |
| out_word | output | 30 | Encoded frame word to the serializer |
| out_sof | output | 1 | High with output word 0 |

## Verification
The assertions assume that frame_start never arrives while a frame is still in progress, and that it is low during reset. The trailer check also relies on a frame's four words arriving on consecutive cycles. The stimulus sends frames back to back or separated by idle gaps of junk words. It pulses reset only during a gap and keeps frame_start low while reset is held. The stimulus changes cal_mode and the trailer only on cycles where the design must ignore them.

// File: rtl/fenc_pkg.sv
package fenc_pkg;
  localparam int WORD_W    = 30;
  localparam int WORDS     = 4;
  localparam int CRC_W     = 16;
  localparam int TRL_W     = 8;
  localparam int SCR_LEN   = 58;
  localparam int SCR_TAP   = 39;
  localparam int COPIES    = 3;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

  localparam int FRAME_W   = WORD_W * WORDS;
  localparam int LAST_BASE = WORD_W * (WORDS - 1);
  localparam int DATA_PAY  = FRAME_W - CRC_W - TRL_W;
  localparam int CAL_PAY   = FRAME_W - TRL_W;
  localparam int DATA_LAST = DATA_PAY - LAST_BASE;
  localparam int CAL_LAST  = CAL_PAY - LAST_BASE;
  localparam int IDX_W     = $clog2(WORDS);
  localparam int NB_W      = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [SCR_LEN-1:0] scr_state_t;
  typedef logic [CRC_W-1:0]   crc_t;
  typedef logic [NB_W-1:0]    nbits_t;

  typedef struct packed {
    scr_state_t state;
    word_t      data;
  } scr_res_t;

  // Scramble the first nb bits of d (MSB first); state[0] is the newest output bit.
  function automatic scr_res_t scr_word(scr_state_t st, word_t d, nbits_t nb);
    scr_res_t r;
    logic     b;
    r.state = st;
    r.data  = d;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(nb)) begin
        b = d[WORD_W-1-i] ^ r.state[SCR_TAP-1] ^ r.state[SCR_LEN-1];
        r.data[WORD_W-1-i] = b;
        r.state = {r.state[SCR_LEN-2:0], b};
      end
    end
    return r;
  endfunction

  // Serial CRC update over the first nb bits of d (MSB first).
  function automatic crc_t crc_word(crc_t c, word_t d, nbits_t nb);
    crc_t r;
    logic fb;
    r = c;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(nb)) begin
        fb = r[CRC_W-1] ^ d[WORD_W-1-i];
        r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/fenc_vote3.sv
module fenc_vote3 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end
endmodule

// File: rtl/fenc_scrambler_tmr.sv
module fenc_scrambler_tmr
  import fenc_pkg::*;
(
  input  logic   clk,
  input  word_t  din,
  input  nbits_t nbits,
  output word_t  dout,
  output logic   disagree
);
  // History copies carry no reset: every copy reloads from the majority each clock.
  scr_state_t rep_q [COPIES];
  scr_state_t voted;
  scr_res_t   res;

  fenc_vote3 #(.W(SCR_LEN)) u_vote (
    .a(rep_q[0]),
    .b(rep_q[1]),
    .c(rep_q[2]),
    .y(voted)
  );

  always_comb res = scr_word(voted, din, nbits);

  always_ff @(posedge clk) begin
    for (int g = 0; g < COPIES; g++) rep_q[g] <= res.state;
  end

  assign dout     = res.data;
  assign disagree = (rep_q[0] != rep_q[1]) | (rep_q[0] != rep_q[2]);
endmodule

// File: rtl/fenc_crc_acc.sv
module fenc_crc_acc
  import fenc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   en,
  input  word_t  din,
  input  nbits_t nbits,
  output crc_t   crc_next
);
  crc_t crc_q;
  crc_t seed;

  always_comb begin
    seed     = restart ? '0 : crc_q;
    crc_next = crc_word(seed, din, nbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= '0;
    else if (en) crc_q <= crc_next;
  end
endmodule

// File: rtl/frame_encoder.sv
module frame_encoder
  import fenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              cal_mode,
  input  logic [WORD_W-1:0] in_word,
  input  logic [TRL_W-1:0]  trailer,
  output logic [WORD_W-1:0] out_word,
  output logic              out_sof
);
  logic             act_q, cal_q;
  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             cur_act, cur_cal, last_word;
  nbits_t           pay_bits, crc_bits;
  word_t            scr_out, frame_word;
  crc_t             crc_nx;
  logic             scr_disagree;

  always_comb begin
    cur_act   = rst_n & (frame_start | act_q);
    cur_idx   = frame_start ? '0 : idx_q;
    cur_cal   = frame_start ? cal_mode : cal_q;
    last_word = (cur_idx == IDX_W'(WORDS - 1));
    if (!cur_act)       pay_bits = '0;
    else if (!last_word) pay_bits = NB_W'(WORD_W);
    else                pay_bits = cur_cal ? NB_W'(CAL_LAST) : NB_W'(DATA_LAST);
    crc_bits = cur_cal ? '0 : pay_bits;
  end

  fenc_scrambler_tmr u_scr (
    .clk     (clk),
    .din     (in_word),
    .nbits   (pay_bits),
    .dout    (scr_out),
    .disagree(scr_disagree)
  );

  fenc_crc_acc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cur_idx == '0),
    .en      (cur_act),
    .din     (in_word),
    .nbits   (crc_bits),
    .crc_next(crc_nx)
  );

  always_comb begin
    if (!cur_act)       frame_word = '0;
    else if (!last_word) frame_word = scr_out;
    else if (cur_cal)   frame_word = {scr_out[WORD_W-1 -: CAL_LAST], trailer};
    else                frame_word = {scr_out[WORD_W-1 -: DATA_LAST], crc_nx, trailer};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      idx_q    <= '0;
      cal_q    <= 1'b0;
      out_word <= '0;
      out_sof  <= 1'b0;
    end else begin
      act_q    <= cur_act & ~last_word;
      idx_q    <= cur_idx + 1'b1;
      cal_q    <= cur_cal;
      out_word <= frame_word;
      out_sof  <= frame_start;
    end
  end
endmodule

// File: rtl/fenc_checker.sv
module fenc_checker
  import fenc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic [TRL_W-1:0]  trailer,
  input logic [WORD_W-1:0] out_word,
  input logic              out_sof,
  input logic              scr_disagree
);
  localparam int POS_W = $clog2(WORDS + 1);
  localparam logic [POS_W-1:0] IDLE = POS_W'(WORDS);

  logic [POS_W-1:0] in_pos_q, out_pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pos_q  <= IDLE;
      out_pos_q <= IDLE;
    end else begin
      in_pos_q  <= frame_start ? POS_W'(1) : (in_pos_q == IDLE ? IDLE : in_pos_q + 1'b1);
      out_pos_q <= out_sof ? POS_W'(1) : (out_pos_q == IDLE ? IDLE : out_pos_q + 1'b1);
    end
  end

  assert_frame_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> in_pos_q == IDLE);

  assert_sof_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_sof == $past(frame_start));

  assert_trailer_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pos_q == POS_W'(WORDS - 1)) |-> out_word[TRL_W-1:0] == $past(trailer));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pos_q == IDLE && !out_sof) |-> out_word == '0);

  assert_copies_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_disagree);
endmodule

bind frame_encoder fenc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .trailer     (trailer),
  .out_word    (out_word),
  .out_sof     (out_sof),
  .scr_disagree(scr_disagree)
);

// File: tb/frame_encoder_tb_top.sv
module frame_encoder_tb_top;
  typedef struct packed {
    logic         cal;
    logic         flip;
    logic [7:0]   trl;
    logic [119:0] frm;
    logic [6:0]   exp_pay;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h5A, 120'h000000000000000000000000000000, 7'd96},
    '{1'b0, 1'b0, 8'hC3, 120'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF, 7'd96},
    '{1'b1, 1'b0, 8'h0F, 120'hAAAAAAAAAAAAAAAAAAAAAAAAAAAAAA, 7'd112},
    '{1'b0, 1'b0, 8'h81, 120'h0123456789ABCDEF0123456789ABCD, 7'd96},
    '{1'b1, 1'b0, 8'hE7, 120'h3C5A96F01E2D4B78C3A5690FE1D2B4, 7'd112},
    '{1'b0, 1'b0, 8'h00, 120'h800000000000000000000000000000, 7'd96},
    '{1'b0, 1'b1, 8'h96, 120'hDEADBEEFCAFEF00D123456789ABCDE, 7'd96},
    '{1'b1, 1'b1, 8'h3A, 120'h13579BDF02468ACE13579BDF02468A, 7'd112}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_start = 1'b0;
  logic         cal_mode = 1'b0;
  logic [29:0]  in_word = '0;
  logic [7:0]   trailer = '0;
  logic [29:0]  out_word;
  logic         out_sof;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  vec_t sent      [64];
  int   start_cyc [64];
  int   n_sent = 0;
  int   n_recv = 0;
  bit   after_reset = 1'b0;

  logic [29:0]  rx [4];
  int           rx_pos = 0;
  bit           cap_valid = 1'b0;
  logic [57:0]  hist = '0;
  int           hist_n = 0;

  frame_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cal_mode(cal_mode),
    .in_word(in_word), .trailer(trailer), .out_word(out_word), .out_sof(out_sof)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference CRC by long division of {payload, 16 zeros} by 0x18005.
  function automatic logic [15:0] ref_crc(input logic [95:0] p);
    logic [111:0] v;
    v = {p, 16'h0000};
    for (int i = 111; i >= 16; i--)
      if (v[i]) v[i -: 17] = v[i -: 17] ^ 17'h18005;
    return v[15:0];
  endfunction

  task automatic send_frame(input vec_t v);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_word     = v.frm[119 - 30*k -: 30];
      frame_start = (k == 0);
      cal_mode    = v.cal ^ (v.flip && k > 0);   // R8: late mode changes
      trailer     = (k == 3) ? v.trl : ~v.trl;   // R3: only word 3 counts
      if (k == 0) begin
        sent[n_sent]      = v;
        start_cyc[n_sent] = cyc;
        n_sent++;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frame_start = 1'b0;
      in_word     = 30'h2AC3_5F1E ^ 30'(k * 30'h0135_79BD);   // junk, must not advance scrambler (R7)
      trailer     = 8'hFF;
    end
  endtask

  task automatic process_frame;
    logic [119:0] rxf;
    vec_t         v;
    int           bad;
    int           cnt;
    logic         s, d;
    string        tag;
    v   = sent[n_recv];
    rxf = {rx[0], rx[1], rx[2], rx[3]};
    check(rxf[7:0] == v.trl, "R3 trailer", 128'(rxf[7:0]), 128'(v.trl));
    if (!v.cal)
      check(rxf[23:8] == ref_crc(v.frm[119 -: 96]), v.flip ? "R8 R4 crc" : "R4 crc",
            128'(rxf[23:8]), 128'(ref_crc(v.frm[119 -: 96])));
    bad = 0;
    cnt = 0;
    for (int i = 0; i < int'(v.exp_pay); i++) begin
      s = rxf[119 - i];
      if (hist_n >= 58) begin
        d = s ^ hist[38] ^ hist[57];
        if (d != v.frm[119 - i]) bad++;
        cnt++;
      end
      hist = {hist[56:0], s};
      hist_n++;
    end
    if (cnt > 0) begin
      if (after_reset)  tag = "R9 descramble";
      else if (v.flip)  tag = "R8 descramble";
      else if (v.cal)   tag = "R5 R7 descramble";
      else              tag = "R6 R7 descramble";
      check(bad == 0, tag, 128'(bad), 128'(0));
      after_reset = 1'b0;
    end
    n_recv++;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cap_valid = 1'b0;
    end else if (out_sof) begin
      check(cyc == start_cyc[n_recv] + 1, "R2 sof timing", 128'(cyc), 128'(start_cyc[n_recv] + 1));
      rx[0]     = out_word;
      rx_pos    = 1;
      cap_valid = 1'b1;
    end else if (cap_valid) begin
      rx[rx_pos] = out_word;
      if (rx_pos == 3) begin
        cap_valid = 1'b0;
        process_frame();
      end
      rx_pos++;
    end else begin
      check(out_word == '0, "R10 idle zero", 128'(out_word), 128'(0));
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(out_word == '0 && out_sof == 1'b0, "R1 in reset", 128'({out_sof, out_word}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_word == '0 && out_sof == 1'b0, "R1 after release", 128'({out_sof, out_word}), 128'(0));

    // Table walk: back to back, then with gaps.
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < NV; i++) begin
        send_frame(VECS[i]);
        if (r == 1) idle(2 + i);
      end
      idle(3);
    end

    // Reset during a gap: history must survive (R9).
    idle(2);
    @(negedge clk);
    rst_n = 1'b0;
    after_reset = 1'b1;
    idle(3);
    check(out_word == '0 && out_sof == 1'b0, "R1 mid reset", 128'({out_sof, out_word}), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_word == '0 && out_sof == 1'b0, "R1 after mid reset", 128'({out_sof, out_word}), 128'(0));
    send_frame(VECS[3]);
    send_frame(VECS[4]);
    send_frame(VECS[6]);
    idle(6);
    check(n_recv == n_sent, "R2 frame count", 128'(n_recv), 128'(n_sent));
    done = 1'b1;
  end

  initial begin
    for (int w = 0; w < 20000 && !done; w++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_recv, n_sent);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule